// File: doc/BRIEF.md
# Ping-pong output gamma LUT

This block is the last colour stage before pixels leave a capture or write-back path. It maps each of three 10-bit colour channels through a piecewise-linear transfer curve held in one of two tables, bank A or bank B. Each bank stores one set of breakpoints per channel. The upper bits of a channel value pick a segment. The lower bits interpolate linearly between that breakpoint and the next one. A bank with 2^SEG_W segments therefore holds 2^SEG_W + 1 breakpoints, and the last one closes the final segment.

Software loads a table through a small host port. It writes an index to set the write pointer, then streams data words. Each accepted word goes to the bank chosen by the host bank bit, into the channels whose mask bits are set, and the pointer then advances by one. The usual flow fills the bank that is not in use while pixels keep flowing through the other one. Software then requests the new bank. The mode and bank request only takes effect on a frame-start strobe, so a frame is never split across two curves. The mode and bank currently in force can be read back on status outputs. A bypass mode passes pixels through unchanged, with the same latency as table mode.

Top module: `gam_pingpong_lut`

## Requirements
- R1: While reset is high and on the first cycle after it, pix_out_vld is 0, pix_out is 0, cur_mode is 0 and cur_bank is 0. Both banks hold all-zero breakpoints after reset.
- R2: cur_mode and cur_bank load ctl_mode and ctl_bank at a clock edge where frame_start is high, and they hold their value at every other edge.
- R3: When cur_mode is 0 (bypass) as a pixel is accepted, pix_out equals that pix_in two cycles later.
- R4: cur_mode values 1 and 3 are reserved and behave exactly like bypass. cur_mode still reports the raw value.
- R5: When cur_mode is 2 (table), cur_bank 0 selects bank A and cur_bank 1 selects bank B for pixels accepted in that cycle.
- R6: host_bank 0 routes data writes to bank A and 1 routes them to bank B. Writes to the bank that is not in use do not change the pixel output.
- R7: host_chan_mask bit 2 enables red, bit 1 green and bit 0 blue. A channel whose bit is clear keeps its stored breakpoint.
- R8: A host_idx_wr pulse loads the write pointer from host_idx. Each host_data_wr stores host_data at the pointer (or at host_idx when both strobes are high together) and then increments the pointer.
- R9: In table mode each channel value v gives segment s = v[9:6] and fraction f = v[5:0]. The output is lo + floor((hi - lo) * f / 64), where lo is breakpoint s and hi is breakpoint s+1, so value 1023 uses the closing breakpoint 16.
- R10: pix_out_vld follows pix_in_vld by exactly two cycles, and pix_out is 0 whenever pix_out_vld is 0. The pixel bus holds red in bits [29:20], green in [19:10] and blue in [9:0].
- R11: Data writes at a pointer beyond the last breakpoint (index 16) are discarded, and the pointer stays where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_idx_wr | input | 1 | Load the host write pointer |
| host_idx | input | SEG_W+1 | Value for the write pointer |
| host_data_wr | input | 1 | Store one breakpoint word |
| host_data | input | PIX_W | Breakpoint word |
| host_chan_mask | input | 3 | Channel write enables: bit 2 red, bit 1 green, bit 0 blue |
| host_bank | input | 1 | Target bank for host writes: 0 A, 1 B |
| ctl_mode | input | 2 | Requested mode: 0 bypass, 2 table, 1 and 3 reserved |
| ctl_bank | input | 1 | Requested active bank: 0 A, 1 B |
| frame_start | input | 1 | Frame boundary strobe; applies the mode and bank request |
| pix_in_vld | input | 1 | Input pixel valid |
| pix_in | input | 3*PIX_W | Input pixel, red high, blue low |
| pix_out_vld | output | 1 | Output pixel valid |
| pix_out | output | 3*PIX_W | Output pixel, same layout |
| cur_mode | output | 2 | Mode in force |
| cur_bank | output | 1 | Bank in force: 0 A, 1 B |

## Verification
A pixel offered in a cycle comes out two clock edges later: one edge captures it together with its fetched breakpoints, and the next registers the interpolated or bypassed result. The bench stamps every expected pixel with the cycle number at which it is due. The monitor checks both the value and that stamp when pix_out_vld rises. Status outputs change one edge after a frame_start pulse, and a host write is visible to a pixel accepted at the next edge. The bench therefore reads status and offers pixels only after the edge that commits the write or the switch. It also offers pixels after a select request that has no frame_start, to confirm the previous bank is still in use.

// File: rtl/gam_lut_pkg.sv
package gam_lut_pkg;

    // Number of colour channels; channel 0 is blue, 1 green, 2 red.
    localparam int CH_N = 3;

    // Default geometry: 10-bit channels, 16 segments.
    localparam int DEF_PIX_W = 10;
    localparam int DEF_SEG_W = 4;

    // Mode encoding of the control and status fields.
    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_RSVD_1 = 2'd1,
        MODE_TABLE  = 2'd2,
        MODE_RSVD_3 = 2'd3
    } gam_mode_e;

    // Only the table encoding enables lookup; reserved codes fall back to bypass.
    function automatic logic mode_uses_table(input gam_mode_e m);
        return m == MODE_TABLE;
    endfunction

endpackage

// File: rtl/gam_host_port.sv
module gam_host_port
    import gam_lut_pkg::*;
#(
    parameter int PIX_W   = DEF_PIX_W,
    parameter int ENTRIES = (1 << DEF_SEG_W) + 1,
    parameter int ADDR_W  = DEF_SEG_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  idx_wr,
    input  logic [ADDR_W-1:0]     idx,
    input  logic                  data_wr,
    input  logic [PIX_W-1:0]      data,
    input  logic [CH_N-1:0]       chan_mask,
    input  logic                  bank,
    output logic [2*CH_N-1:0]     wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [PIX_W-1:0]      wr_data
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(ENTRIES - 1);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] addr_now;
    logic              in_range;
    logic              commit;

    // A pointer load in the same cycle as a data write takes effect at once.
    assign addr_now = idx_wr ? idx : ptr_q;
    assign in_range = addr_now <= LAST;
    assign commit   = data_wr && in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (commit) begin
            ptr_q <= addr_now + 1'b1;
        end else if (idx_wr) begin
            ptr_q <= idx;
        end
    end

    // Bank-major enable vector: bit b*CH_N + c writes channel c of bank b.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar c = 0; c < CH_N; c++) begin : g_ch
            assign wr_en[b*CH_N + c] = commit && (bank == 1'(b)) && chan_mask[c];
        end
    end

    assign wr_addr = addr_now;
    assign wr_data = data;

endmodule

// File: rtl/gam_lut_bank.sv
module gam_lut_bank
    import gam_lut_pkg::*;
#(
    parameter int PIX_W   = DEF_PIX_W,
    parameter int SEG_W   = DEF_SEG_W,
    parameter int ENTRIES = (1 << DEF_SEG_W) + 1,
    parameter int ADDR_W  = DEF_SEG_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [PIX_W-1:0]  wdata,
    input  logic [SEG_W-1:0]  rseg,
    output logic [PIX_W-1:0]  rd_lo,
    output logic [PIX_W-1:0]  rd_hi
);

    logic [PIX_W-1:0]  mem [ENTRIES];
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Both ends of the segment are read in the same cycle.
    assign lo_addr = ADDR_W'(rseg);
    assign hi_addr = ADDR_W'(rseg) + 1'b1;
    assign rd_lo   = mem[lo_addr];
    assign rd_hi   = mem[hi_addr];

endmodule

// File: rtl/gam_frame_ctl.sv
module gam_frame_ctl
    import gam_lut_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic [1:0] ctl_mode,
    input  logic       ctl_bank,
    output gam_mode_e  mode_q,
    output logic       bank_q,
    output logic       use_table
);

    // The request is applied only at a frame boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_BYPASS;
            bank_q <= 1'b0;
        end else if (frame_start) begin
            mode_q <= gam_mode_e'(ctl_mode);
            bank_q <= ctl_bank;
        end
    end

    assign use_table = mode_uses_table(mode_q);

endmodule

// File: rtl/gam_interp_lane.sv
module gam_interp_lane
    import gam_lut_pkg::*;
#(
    parameter int PIX_W  = DEF_PIX_W,
    parameter int FRAC_W = DEF_PIX_W - DEF_SEG_W
) (
    input  logic [PIX_W-1:0]  lo,
    input  logic [PIX_W-1:0]  hi,
    input  logic [FRAC_W-1:0] frac,
    output logic [PIX_W-1:0]  y
);

    localparam int PROD_W = PIX_W + FRAC_W + 2;

    logic signed [PIX_W:0]    diff;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] step;

    // Signed slope so that falling curves interpolate too; the shift floors.
    assign diff = $signed({1'b0, hi}) - $signed({1'b0, lo});
    assign prod = PROD_W'(diff) * PROD_W'($signed({1'b0, frac}));
    assign step = prod >>> FRAC_W;
    assign y    = PIX_W'(step + $signed(PROD_W'(lo)));

endmodule

// File: rtl/gam_pingpong_lut.sv
module gam_pingpong_lut
    import gam_lut_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int SEG_W = DEF_SEG_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_idx_wr,
    input  logic [SEG_W:0]        host_idx,
    input  logic                  host_data_wr,
    input  logic [PIX_W-1:0]      host_data,
    input  logic [2:0]            host_chan_mask,
    input  logic                  host_bank,
    input  logic [1:0]            ctl_mode,
    input  logic                  ctl_bank,
    input  logic                  frame_start,
    input  logic                  pix_in_vld,
    input  logic [3*PIX_W-1:0]    pix_in,
    output logic                  pix_out_vld,
    output logic [3*PIX_W-1:0]    pix_out,
    output logic [1:0]            cur_mode,
    output logic                  cur_bank
);

    localparam int FRAC_W  = PIX_W - SEG_W;
    localparam int ENTRIES = (1 << SEG_W) + 1;
    localparam int ADDR_W  = SEG_W + 1;
    localparam int BUS_W   = CH_N * PIX_W;

    // ---------------- host write port ----------------
    logic [2*CH_N-1:0] wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [PIX_W-1:0]  wr_data;

    gam_host_port #(
        .PIX_W  (PIX_W),
        .ENTRIES(ENTRIES),
        .ADDR_W (ADDR_W)
    ) u_host (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (host_idx_wr),
        .idx      (host_idx),
        .data_wr  (host_data_wr),
        .data     (host_data),
        .chan_mask(host_chan_mask),
        .bank     (host_bank),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // ---------------- frame-aligned control ----------------
    gam_mode_e mode_q;
    logic      bank_q;
    logic      use_table;

    gam_frame_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .ctl_mode   (ctl_mode),
        .ctl_bank   (ctl_bank),
        .mode_q     (mode_q),
        .bank_q     (bank_q),
        .use_table  (use_table)
    );

    assign cur_mode = mode_q;
    assign cur_bank = bank_q;

    // ---------------- two banks, one table per channel ----------------
    logic [2*BUS_W-1:0] rd_lo;
    logic [2*BUS_W-1:0] rd_hi;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar c = 0; c < CH_N; c++) begin : g_ch
            gam_lut_bank #(
                .PIX_W  (PIX_W),
                .SEG_W  (SEG_W),
                .ENTRIES(ENTRIES),
                .ADDR_W (ADDR_W)
            ) u_tab (
                .clk  (clk),
                .rst  (rst),
                .we   (wr_en[b*CH_N + c]),
                .waddr(wr_addr),
                .wdata(wr_data),
                .rseg (pix_in[c*PIX_W + FRAC_W +: SEG_W]),
                .rd_lo(rd_lo[(b*CH_N + c)*PIX_W +: PIX_W]),
                .rd_hi(rd_hi[(b*CH_N + c)*PIX_W +: PIX_W])
            );
        end
    end

    // Pick the bank in force for each channel.
    logic [BUS_W-1:0] lo_pick;
    logic [BUS_W-1:0] hi_pick;

    for (genvar c = 0; c < CH_N; c++) begin : g_pick
        assign lo_pick[c*PIX_W +: PIX_W] = bank_q ? rd_lo[(CH_N + c)*PIX_W +: PIX_W]
                                                  : rd_lo[c*PIX_W +: PIX_W];
        assign hi_pick[c*PIX_W +: PIX_W] = bank_q ? rd_hi[(CH_N + c)*PIX_W +: PIX_W]
                                                  : rd_hi[c*PIX_W +: PIX_W];
    end

    // ---------------- stage 1: capture pixel and breakpoints ----------------
    logic             s1_vld;
    logic             s1_tab;
    logic [BUS_W-1:0] s1_pix;
    logic [BUS_W-1:0] s1_lo;
    logic [BUS_W-1:0] s1_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1_tab <= 1'b0;
            s1_pix <= '0;
            s1_lo  <= '0;
            s1_hi  <= '0;
        end else begin
            s1_vld <= pix_in_vld;
            s1_tab <= use_table;
            s1_pix <= pix_in;
            s1_lo  <= lo_pick;
            s1_hi  <= hi_pick;
        end
    end

    // ---------------- interpolation lanes ----------------
    logic [BUS_W-1:0] lane_y;

    for (genvar c = 0; c < CH_N; c++) begin : g_lane
        gam_interp_lane #(
            .PIX_W (PIX_W),
            .FRAC_W(FRAC_W)
        ) u_lane (
            .lo  (s1_lo[c*PIX_W +: PIX_W]),
            .hi  (s1_hi[c*PIX_W +: PIX_W]),
            .frac(s1_pix[c*PIX_W +: FRAC_W]),
            .y   (lane_y[c*PIX_W +: PIX_W])
        );
    end

    // ---------------- stage 2: output register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out_vld <= 1'b0;
            pix_out     <= '0;
        end else begin
            pix_out_vld <= s1_vld;
            if (!s1_vld) begin
                pix_out <= '0;
            end else if (s1_tab) begin
                pix_out <= lane_y;
            end else begin
                pix_out <= s1_pix;
            end
        end
    end

endmodule

// File: rtl/gam_pingpong_lut_chk.sv
module gam_pingpong_lut_chk #(
    parameter int PIX_W = 10,
    parameter int SEG_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_start,
    input logic [1:0]         ctl_mode,
    input logic               ctl_bank,
    input logic               pix_in_vld,
    input logic [3*PIX_W-1:0] pix_in,
    input logic               pix_out_vld,
    input logic [3*PIX_W-1:0] pix_out,
    input logic [1:0]         cur_mode,
    input logic               cur_bank
);

    // R1: reset clears outputs and status
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!pix_out_vld && pix_out == '0 && cur_mode == 2'd0 && !cur_bank));

    // R2: status moves only at a frame boundary
    p_ctl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(cur_mode) && $stable(cur_bank)));

    // R2: status takes the request at a frame boundary
    p_ctl_load_r2: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (cur_mode == $past(ctl_mode) && cur_bank == $past(ctl_bank)));

    // R3: bypass is a pure two-cycle delay
    p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
        (pix_in_vld && cur_mode == 2'd0) |-> ##2 (pix_out == $past(pix_in, 2)));

    // R4: reserved codes behave as bypass
    p_reserved_r4: assert property (@(posedge clk) disable iff (rst)
        (pix_in_vld && (cur_mode == 2'd1 || cur_mode == 2'd3)) |-> ##2 (pix_out == $past(pix_in, 2)));

    // R10: valid comes out two cycles after it goes in
    p_vld_lat_r10: assert property (@(posedge clk) disable iff (rst)
        pix_in_vld |-> ##2 pix_out_vld);

    // R10: no output without an input two cycles earlier
    p_vld_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !pix_in_vld |-> ##2 !pix_out_vld);

    // R10: the bus is zero when not valid
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !pix_out_vld |-> (pix_out == '0));

endmodule

bind gam_pingpong_lut gam_pingpong_lut_chk #(.PIX_W(PIX_W), .SEG_W(SEG_W)) u_chk (.*);

// File: tb/test_gam_pingpong_lut.sv
module test_gam_pingpong_lut;

    localparam int PW = 10;
    localparam int SW = 4;
    localparam int FW = PW - SW;
    localparam int NE = (1 << SW) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_idx_wr = 1'b0;
    logic [SW:0]   host_idx = '0;
    logic          host_data_wr = 1'b0;
    logic [PW-1:0] host_data = '0;
    logic [2:0]    host_chan_mask = '0;
    logic          host_bank = 1'b0;
    logic [1:0]    ctl_mode = 2'd0;
    logic          ctl_bank = 1'b0;
    logic          frame_start = 1'b0;
    logic          pix_in_vld = 1'b0;
    logic [3*PW-1:0] pix_in = '0;
    logic          pix_out_vld;
    logic [3*PW-1:0] pix_out;
    logic [1:0]    cur_mode;
    logic          cur_bank;

    gam_pingpong_lut #(.PIX_W(PW), .SEG_W(SW)) i_gam_pingpong_lut (
        .clk(clk), .rst(rst),
        .host_idx_wr(host_idx_wr), .host_idx(host_idx),
        .host_data_wr(host_data_wr), .host_data(host_data),
        .host_chan_mask(host_chan_mask), .host_bank(host_bank),
        .ctl_mode(ctl_mode), .ctl_bank(ctl_bank), .frame_start(frame_start),
        .pix_in_vld(pix_in_vld), .pix_in(pix_in),
        .pix_out_vld(pix_out_vld), .pix_out(pix_out),
        .cur_mode(cur_mode), .cur_bank(cur_bank)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    int checks = 0;
    int failures = 0;

    // Reference model of both banks and of the applied control.
    int mdl [2][3][NE];
    int ptr = 0;
    int app_mode = 0;
    int app_bank = 0;

    // Scoreboard queues.
    int              q_due [$];
    logic [3*PW-1:0] q_val [$];
    string           q_tag [$];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [3*PW-1:0] mk(input int r, input int g, input int b);
        return {PW'(r), PW'(g), PW'(b)};
    endfunction

    function automatic logic [3*PW-1:0] expect_pix(input logic [3*PW-1:0] p);
        logic [3*PW-1:0] r;
        if (app_mode != 2) return p;
        r = '0;
        for (int c = 0; c < 3; c++) begin
            int v, s, f, lo, hi, y;
            v  = int'(p[c*PW +: PW]);
            s  = v >> FW;
            f  = v & ((1 << FW) - 1);
            lo = mdl[app_bank][c][s];
            hi = mdl[app_bank][c][s+1];
            y  = lo + (((hi - lo) * f) >>> FW);
            r[c*PW +: PW] = PW'(y);
        end
        return r;
    endfunction

    task automatic host_index(input int i);
        host_idx_wr = 1'b1;
        host_idx    = (SW+1)'(i);
        ptr         = i;
        @(negedge clk);
        host_idx_wr = 1'b0;
    endtask

    task automatic host_write(input int d, input int mask, input int bank);
        host_data_wr   = 1'b1;
        host_data      = PW'(d);
        host_chan_mask = 3'(mask);
        host_bank      = 1'(bank);
        if (ptr < NE) begin
            for (int c = 0; c < 3; c++) if (mask[c]) mdl[bank][c][ptr] = d;
            ptr++;
        end
        @(negedge clk);
        host_data_wr = 1'b0;
    endtask

    task automatic frame(input int m, input int b);
        ctl_mode    = 2'(m);
        ctl_bank    = 1'(b);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        app_mode    = m;
        app_bank    = b;
    endtask

    task automatic send(input logic [3*PW-1:0] p, input string tag);
        q_due.push_back(cyc + 2);
        q_val.push_back(expect_pix(p));
        q_tag.push_back(tag);
        pix_in_vld = 1'b1;
        pix_in     = p;
        @(negedge clk);
        pix_in_vld = 1'b0;
        pix_in     = '0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    // Monitor: compare each output against the queued expectation.
    always @(negedge clk) begin
        if (!rst) begin
            if (pix_out_vld) begin
                if (q_val.size() == 0) begin
                    check(1'b0, "R10 unexpected output", longint'(pix_out), 0);
                end else begin
                    int              due;
                    logic [3*PW-1:0] ev;
                    string           tg;
                    due = q_due.pop_front();
                    ev  = q_val.pop_front();
                    tg  = q_tag.pop_front();
                    check(pix_out == ev, tg, longint'(pix_out), longint'(ev));
                    check(due == cyc, "R10 latency", cyc, due);
                end
            end else if (q_due.size() != 0 && q_due[0] < cyc) begin
                check(1'b0, "R10 missing output", cyc, q_due[0]);
                void'(q_due.pop_front());
                void'(q_val.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 3; c++)
                for (int i = 0; i < NE; i++) mdl[b][c][i] = 0;

        repeat (3) @(negedge clk);
        // R1: reset state, still in reset
        check(!pix_out_vld, "R1 vld in reset", pix_out_vld, 0);
        check(cur_mode == 2'd0, "R1 mode in reset", cur_mode, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!pix_out_vld && pix_out == '0, "R1 outputs after reset", pix_out, 0);
        check(cur_mode == 2'd0 && !cur_bank, "R1 status after reset", {cur_mode, cur_bank}, 0);

        // R3, R10: bypass after reset, back-to-back and spaced
        send(mk(0, 0, 0), "R3 bypass zero");
        send(mk(1023, 1023, 1023), "R3 bypass full");
        send(mk(17, 512, 999), "R3 bypass mixed");
        @(negedge clk);
        send(mk(300, 2, 700), "R3 bypass spaced");
        drain();

        // R8: load bank A, all channels at once, rising ramp
        host_index(0);
        for (int i = 0; i < NE; i++) host_write(i * 60, 7, 0);

        // R2: request without frame strobe has no effect
        ctl_mode = 2'd2;
        ctl_bank = 1'b0;
        repeat (2) @(negedge clk);
        check(cur_mode == 2'd0, "R2 no strobe", cur_mode, 0);
        send(mk(700, 100, 5), "R2 still bypass");
        drain();
        frame(2, 0);
        check(cur_mode == 2'd2 && cur_bank == 1'b0, "R2 strobe applies", {cur_mode, cur_bank}, 4);

        // R5, R9: lookup through bank A
        send(mk(0, 0, 0), "R9 table zero");
        send(mk(1023, 1023, 1023), "R9 closing breakpoint");
        send(mk(700, 64, 63), "R5 bank A mixed");
        send(mk(320, 959, 33), "R9 table mixed");
        drain();

        // R6, R7, R8: load bank B one channel at a time while A is active
        host_index(0);
        for (int i = 0; i < NE; i++) host_write(1023 - i * 60, 4, 1);
        host_index(0);
        for (int i = 0; i < NE; i++) host_write(i * i * 3, 2, 1);
        host_index(0);
        for (int i = 0; i < NE; i++) host_write(500 + i * 7, 1, 1);
        send(mk(100, 500, 1000), "R6 inactive bank load");
        ctl_bank = 1'b1;
        @(negedge clk);
        send(mk(100, 500, 1000), "R2 bank request pending");
        drain();

        frame(2, 1);
        check(cur_bank == 1'b1 && cur_mode == 2'd2, "R2 switch to B", {cur_mode, cur_bank}, 5);
        send(mk(100, 500, 1000), "R5 bank B falling red");
        send(mk(1023, 0, 640), "R5 bank B mixed");
        send(mk(63, 831, 1023), "R9 bank B");
        drain();

        // R11: writes past the closing breakpoint are discarded
        host_index(16);
        host_write(111, 7, 1);
        host_write(222, 7, 1);
        host_write(333, 7, 1);
        send(mk(1023, 1023, 1023), "R11 overrun");
        send(mk(0, 0, 0), "R11 low entry untouched");
        drain();

        // R7: blue-only write leaves red and green
        host_index(5);
        host_write(77, 1, 1);
        send(mk(320, 320, 320), "R7 blue mask only");
        // R7: red-only write
        host_index(5);
        host_write(901, 4, 1);
        send(mk(320, 330, 340), "R7 red mask only");
        drain();

        // R6: writing bank A while B is in use does not reach the output
        host_index(0);
        host_write(999, 7, 0);
        host_write(999, 7, 0);
        send(mk(0, 10, 40), "R6 write to idle bank");
        drain();

        // R8: simultaneous pointer load and data write uses the new index
        host_idx_wr    = 1'b1;
        host_idx       = 5'd3;
        host_data_wr   = 1'b1;
        host_data      = 10'd444;
        host_chan_mask = 3'd2;
        host_bank      = 1'b1;
        ptr = 3;
        mdl[1][1][3] = 444;
        ptr = 4;
        @(negedge clk);
        host_idx_wr  = 1'b0;
        host_data_wr = 1'b0;
        host_write(555, 2, 1);
        send(mk(192, 192, 192), "R8 load with write");
        send(mk(256, 256, 256), "R8 increment after load");
        drain();

        // R4: reserved codes act as bypass and report raw value
        frame(3, 1);
        check(cur_mode == 2'd3, "R4 reserved 3 status", cur_mode, 3);
        send(mk(100, 500, 1000), "R4 reserved 3 passthrough");
        drain();
        frame(1, 0);
        check(cur_mode == 2'd1 && !cur_bank, "R4 reserved 1 status", {cur_mode, cur_bank}, 2);
        send(mk(1023, 1, 512), "R4 reserved 1 passthrough");
        drain();

        // R3: explicit bypass again
        frame(0, 1);
        send(mk(7, 8, 9), "R3 bypass after table");
        drain();

        check(q_due.size() == 0, "R10 queue empty", q_due.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule